// File: doc/BRIEF.md
# GPIO Port with Per-Pin Override Multiplexing

This block is one general-purpose I/O port of `WIDTH` pins, eight by default. Software controls each pin through three registers that sit behind one set of strobes: a direction register, an output register and a pin register. When the direction bit is 1 the output register bit drives the pad. When the direction bit is 0 the same output register bit asks for the pad pull-up. Writing ones to the pin register flips the matching output bits. Reading the pin register returns the pad level after a two-stage synchronizer.

On-chip peripherals can take over any pin without touching the registers. Each pin has four enable/value pairs, one for each of the pad pull-up, the output enable, the output level and the digital input enable. A per-pin toggle request from a peripheral also flips the output bit. A shared sleep input shuts off the digital input path, and a pin's input-enable override can keep that path open or closed regardless of sleep. A shared pull-up kill input blocks every register-derived pull-up. The synchronized input also goes back to the peripherals.

Top module: `gpio_override_port`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the direction and output registers. A direction or output read returns the stored register bits, never the overridden pad values.
- R2: While rst_n is low, pad_pu is 0 on every pin, even when a pull-up override requests 1.
- R3: Without a pull-up override, pad_pu for a pin is 1 only when its direction bit is 0, its output bit is 1 and pullup_off is 0.
- R4: For each pin and for each of pull-up, output enable and output level, an override enable of 1 replaces the register-derived value with the override value. An enable of 0 keeps the register-derived value. pullup_off has no effect on a pin whose pull-up is overridden.
- R5: A pin-register write (wr_tgl) flips every output bit where wdata is 1 and leaves bits where wdata is 0 unchanged. An output-register write (wr_out) in the same cycle takes precedence and loads wdata.
- R6: Each cycle in which a pin's tgl_ovr_en is 1 and wr_out is 0, that pin's output bit flips. With no write strobe and no toggle request, the output register holds.
- R7: A pad level is shown on din_sync, and on a pin-register read, after the second rising clock edge that follows it. It is not shown after the first.
- R8: The digital input enable of a pin is the inverse of sleep unless ie_ovr_en is 1, in which case it is ie_ovr_val. A disabled pin reads 0 on din_sync and on a pin-register read.
- R9: rdata is combinational. rd_dir has the highest priority, then rd_out, then rd_pin. With no read strobe, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Write strobe for the direction register |
| wr_out | input | 1 | Write strobe for the output register |
| wr_tgl | input | 1 | Write strobe for the pin register (toggle) |
| wdata | input | WIDTH | Write data |
| rd_dir | input | 1 | Read strobe for the direction register |
| rd_out | input | 1 | Read strobe for the output register |
| rd_pin | input | 1 | Read strobe for the synchronized pin levels |
| rdata | output | WIDTH | Read data |
| sleep | input | 1 | Shared digital-input shutoff |
| pullup_off | input | 1 | Shared kill for register-derived pull-ups |
| pu_ovr_en | input | WIDTH | Pull-up override enable per pin |
| pu_ovr_val | input | WIDTH | Pull-up override value per pin |
| dir_ovr_en | input | WIDTH | Output-enable override enable per pin |
| dir_ovr_val | input | WIDTH | Output-enable override value per pin |
| out_ovr_en | input | WIDTH | Output-level override enable per pin |
| out_ovr_val | input | WIDTH | Output-level override value per pin |
| ie_ovr_en | input | WIDTH | Input-enable override enable per pin |
| ie_ovr_val | input | WIDTH | Input-enable override value per pin |
| tgl_ovr_en | input | WIDTH | Per-pin toggle request from a peripheral |
| pad_in | input | WIDTH | Pad levels |
| pad_out | output | WIDTH | Output level to the pads |
| pad_oe | output | WIDTH | Output enable to the pads |
| pad_pu | output | WIDTH | Pull-up enable to the pads |
| din_sync | output | WIDTH | Synchronized, gated input to peripherals |

## Verification
The override muxes are tried with a vector table that mixes register contents with partial override masks, so that overridden and plain bits sit side by side within one byte. This separates a swapped enable/value from a missing mux. The table also sets pullup_off both with and without pull-up overrides, which shows whether the kill applies only to derived pull-ups. Toggle tests use write data with both ones and zeros, a write collision and a peripheral toggle request, to tell flip from load and from hold. Input-path tests step a pad change edge by edge and switch sleep against both override polarities.

// File: rtl/gpio_override_port.sv
module gpio_override_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_out,
  input  logic             wr_tgl,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_dir,
  input  logic             rd_out,
  input  logic             rd_pin,
  output logic [WIDTH-1:0] rdata,
  input  logic             sleep,
  input  logic             pullup_off,
  input  logic [WIDTH-1:0] pu_ovr_en,
  input  logic [WIDTH-1:0] pu_ovr_val,
  input  logic [WIDTH-1:0] dir_ovr_en,
  input  logic [WIDTH-1:0] dir_ovr_val,
  input  logic [WIDTH-1:0] out_ovr_en,
  input  logic [WIDTH-1:0] out_ovr_val,
  input  logic [WIDTH-1:0] ie_ovr_en,
  input  logic [WIDTH-1:0] ie_ovr_val,
  input  logic [WIDTH-1:0] tgl_ovr_en,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  output logic [WIDTH-1:0] din_sync
);

  logic [WIDTH-1:0] dir_q, out_q, sync1_q, sync2_q;
  logic [WIDTH-1:0] flip_mask, pu_norm, in_en, pin_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;

  assign flip_mask = (wr_tgl ? wdata : '0) | tgl_ovr_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      out_q <= '0;
    else if (wr_out) out_q <= wdata;
    else             out_q <= out_q ^ flip_mask;

  assign pu_norm = ~dir_q & out_q & {WIDTH{~pullup_off}};
  assign pad_pu  = {WIDTH{rst_n}} & ((pu_ovr_en & pu_ovr_val) | (~pu_ovr_en & pu_norm));
  assign pad_oe  = (dir_ovr_en & dir_ovr_val) | (~dir_ovr_en & dir_q);
  assign pad_out = (out_ovr_en & out_ovr_val) | (~out_ovr_en & out_q);

  assign in_en = (ie_ovr_en & ie_ovr_val) | (~ie_ovr_en & {WIDTH{~sleep}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in & in_en;
      sync2_q <= sync1_q;
    end

  assign pin_val  = sync2_q & in_en;
  assign din_sync = pin_val;

  always_comb begin
    if (rd_dir)      rdata = dir_q;
    else if (rd_out) rdata = out_q;
    else if (rd_pin) rdata = pin_val;
    else             rdata = '0;
  end

  a_r1_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));

  a_r3_kill_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_off && pu_ovr_en == '0) |-> pad_pu == '0);

  a_r5_pin_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tgl && !wr_out) |=> out_q == ($past(out_q) ^ $past(wdata | tgl_ovr_en)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_out && !wr_tgl && tgl_ovr_en == '0) |=> $stable(out_q));

  a_r8_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && ie_ovr_en == '0) |-> din_sync == '0);

endmodule

// File: tb/test_gpio_override_port.sv
module test_gpio_override_port;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_dir = 0, wr_out = 0, wr_tgl = 0, rd_dir = 0, rd_out = 0, rd_pin = 0;
  logic sleep = 0, pullup_off = 0;
  logic [W-1:0] wdata = '0, pad_in = '0;
  logic [W-1:0] pu_ovr_en = '0, pu_ovr_val = '0, dir_ovr_en = '0, dir_ovr_val = '0;
  logic [W-1:0] out_ovr_en = '0, out_ovr_val = '0, ie_ovr_en = '0, ie_ovr_val = '0;
  logic [W-1:0] tgl_ovr_en = '0;
  logic [W-1:0] rdata, pad_out, pad_oe, pad_pu, din_sync;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpio_override_port #(.WIDTH(W)) i_gpio_override_port (
    .clk, .rst_n, .wr_dir, .wr_out, .wr_tgl, .wdata, .rd_dir, .rd_out, .rd_pin,
    .rdata, .sleep, .pullup_off, .pu_ovr_en, .pu_ovr_val, .dir_ovr_en,
    .dir_ovr_val, .out_ovr_en, .out_ovr_val, .ie_ovr_en, .ie_ovr_val,
    .tgl_ovr_en, .pad_in, .pad_out, .pad_oe, .pad_pu, .din_sync
  );

  typedef struct packed {
    logic [W-1:0] dw, ow, doe, dov, ooe, oov, puoe, puov;
    logic         pud;
    logic [W-1:0] e_oe, e_out, e_pu;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'h0F, 8'hAA, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h0F, 8'hAA, 8'hA0},
    '{8'h0F, 8'hAA, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h0F, 8'hAA, 8'h00},
    '{8'h00, 8'hFF, 8'hF0, 8'h30, 8'h0F, 8'h05, 8'h03, 8'h01, 1'b0, 8'h30, 8'hF5, 8'hFD},
    '{8'h55, 8'h33, 8'hFF, 8'h00, 8'hFF, 8'hC3, 8'hF0, 8'hA0, 1'b1, 8'h00, 8'hC3, 8'hA0},
    '{8'h00, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h81, 8'h80, 1'b0, 8'h00, 8'h3C, 8'hBC}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int kind, input logic [W-1:0] d);
    wdata = d;
    wr_dir = (kind == 0);
    wr_out = (kind == 1);
    wr_tgl = (kind == 2);
    step();
    wr_dir = 0; wr_out = 0; wr_tgl = 0;
  endtask

  task automatic rd(input int kind, output logic [W-1:0] v);
    rd_dir = (kind == 0);
    rd_out = (kind == 1);
    rd_pin = (kind == 2);
    #1 v = rdata;
    rd_dir = 0; rd_out = 0; rd_pin = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    pu_ovr_en = 8'hFF; pu_ovr_val = 8'hFF;
    step();
    chk("R2 pull-up in reset", pad_pu, 8'h00);
    rd(0, v); chk("R1 dir after reset", v, 8'h00);
    rd(1, v); chk("R1 out after reset", v, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R4 pull-up override after reset", pad_pu, 8'hFF);
    pu_ovr_en = '0; pu_ovr_val = '0;

    for (int i = 0; i < 5; i++) begin
      wr(0, VECS[i].dw);
      wr(1, VECS[i].ow);
      dir_ovr_en = VECS[i].doe; dir_ovr_val = VECS[i].dov;
      out_ovr_en = VECS[i].ooe; out_ovr_val = VECS[i].oov;
      pu_ovr_en  = VECS[i].puoe; pu_ovr_val = VECS[i].puov;
      pullup_off = VECS[i].pud;
      #1;
      chk("R4 pad_oe", pad_oe, VECS[i].e_oe);
      chk("R4 pad_out", pad_out, VECS[i].e_out);
      chk("R3 R4 pad_pu", pad_pu, VECS[i].e_pu);
      rd(0, v); chk("R1 dir readback", v, VECS[i].dw);
      rd(1, v); chk("R1 out readback", v, VECS[i].ow);
      dir_ovr_en = '0; dir_ovr_val = '0; out_ovr_en = '0; out_ovr_val = '0;
      pu_ovr_en = '0; pu_ovr_val = '0; pullup_off = 0;
    end

    wr(1, 8'hAA);
    wr(2, 8'h0F);
    rd(1, v); chk("R5 pin write flips ones", v, 8'hA5);
    wr(2, 8'h00);
    rd(1, v); chk("R5 pin write of zeros", v, 8'hA5);
    wdata = 8'h11; wr_out = 1; wr_tgl = 1;
    step();
    wr_out = 0; wr_tgl = 0;
    rd(1, v); chk("R5 port write wins", v, 8'h11);

    tgl_ovr_en = 8'h81;
    step();
    tgl_ovr_en = '0;
    rd(1, v); chk("R6 toggle override", v, 8'h90);
    step();
    rd(1, v); chk("R6 hold", v, 8'h90);

    wr(0, 8'h3C);
    rd(3, v); chk("R9 no strobe", v, 8'h00);
    rd_dir = 1; rd_out = 1;
    #1 chk("R9 dir priority", rdata, 8'h3C);
    rd_dir = 0;
    #1 chk("R9 out over pin", rdata, 8'h90);
    rd_out = 0;

    pad_in = 8'h5A;
    step();
    chk("R7 not after one edge", din_sync, 8'h00);
    step();
    chk("R7 after two edges", din_sync, 8'h5A);
    rd(2, v); chk("R7 pin read", v, 8'h5A);

    sleep = 1;
    #1 chk("R8 sleep gates input", din_sync, 8'h00);
    rd(2, v); chk("R8 sleep pin read", v, 8'h00);
    ie_ovr_en = 8'h0F; ie_ovr_val = 8'h0F;
    step(); step();
    chk("R8 forced enable in sleep", din_sync, 8'h0A);
    sleep = 0; ie_ovr_en = 8'hF0; ie_ovr_val = 8'h00;
    step(); step();
    chk("R8 forced disable awake", din_sync, 8'h0A);
    ie_ovr_en = '0; ie_ovr_val = '0;
    step(); step();
    chk("R8 override released", din_sync, 8'h5A);

    finish_run();
  end
endmodule